// File: doc/BRIEF.md
# Internal Data Address Decoder

This block turns one internal data access per cycle into a physical location. The access can be direct (8-bit address), indirect (8-bit pointer value), register (R0–R7 of the current bank) or bit (8-bit bit address). The result is registered and shows up one clock later. It names which storage is hit: the low 128 RAM bytes, the high 128 RAM bytes or the special-function-register (SFR) space. It also gives the byte address inside that space, a bit index, and whether a write may go through.

The range 80H–FFH reaches SFR space when addressed directly and the high RAM half when reached through a pointer. The low half 00H–7FH is shared by both modes. Register operands sit in the lowest 32 bytes, in four banks of eight. Bit addresses below 80H land in the sixteen bytes from 20H to 2FH. Bit addresses from 80H upward land in the SFRs whose address is a multiple of eight.

For an indirect access the pointer register (R0 or R1 of the current bank) is read outside the block. To make that possible, the block always presents that register's byte address combinationally, and takes the pointer contents back on `ptrData`. A parameter states whether the high RAM half exists. When it does not, a pointer access above 7FH is flagged invalid and any write to it is dropped.

Top module: `idataDecoder`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `outValid`, `tgtSel`, `byteAddr`, `bitIdx`, `invalid` and `wrEn` are all zero.
- R2: A direct (`accKind`=0) or indirect (`accKind`=1) access whose effective address (`addrIn` for direct, `ptrData` for indirect) is below 80H gives `tgtSel`=1 (low RAM) and `byteAddr` equal to that address.
- R3: A direct access to 80H–FFH gives `tgtSel`=3 (SFR) with `byteAddr`=`addrIn`.
- R4: With `HAS_UPPER`=1, an indirect access whose `ptrData` is 80H–FFH gives `tgtSel`=2 (high RAM) with `byteAddr`=`ptrData`.
- R5: A register access (`accKind`=2) gives `tgtSel`=1 and `byteAddr` = `bankSel`*8 + `addrIn[2:0]`.
- R6: `ptrRegAddr` always equals `bankSel`*8 + `addrIn[0]`, combinationally, in the same cycle.
- R7: A bit access (`accKind`=3) with `addrIn` below 80H gives `tgtSel`=1, `byteAddr` = 20H + `addrIn[6:3]`, `bitIdx` = `addrIn[2:0]`.
- R8: A bit access with `addrIn` at 80H or above gives `tgtSel`=3, `byteAddr` = `addrIn` with bits [2:0] cleared, `bitIdx` = `addrIn[2:0]`.
- R9: For any access other than a bit access, `bitIdx` is 0.
- R10: With `HAS_UPPER`=0, an indirect access with `ptrData` at 80H or above gives `tgtSel`=0, `invalid`=1 and `wrEn`=0 even when `isWrite` is 1. Indirect accesses below 80H are unaffected.
- R11: `wrEn` equals `isWrite` of the registered access whenever `invalid` is 0. With `HAS_UPPER`=1, `invalid` is never raised.
- R12: Results appear exactly one clock after the access. A cycle with `accValid`=0 gives `outValid`=0 and `tgtSel`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accValid | input | 1 | An access is presented this cycle |
| accKind | input | 2 | 0 direct, 1 indirect, 2 register, 3 bit |
| addrIn | input | 8 | Direct address, register number, pointer select (bit 0) or bit address |
| ptrData | input | 8 | Contents of the selected pointer register (indirect only) |
| bankSel | input | 2 | Register bank select |
| isWrite | input | 1 | Access is a write |
| ptrRegAddr | output | 8 | Byte address of R0/R1 in the current bank |
| outValid | output | 1 | Registered result is valid |
| tgtSel | output | 2 | 0 none, 1 low RAM, 2 high RAM, 3 SFR |
| byteAddr | output | 8 | Byte address inside the selected space |
| bitIdx | output | 3 | Bit position inside the byte |
| invalid | output | 1 | Pointer access to an absent high RAM half |
| wrEn | output | 1 | Write may proceed |

## Verification
An indirect access does two jobs in the same cycle. The pointer register's location is resolved through the bank bits on `ptrRegAddr`, and the target is decoded from the returned `ptrData`. The bench provokes this with indirect vectors whose bank, pointer select and pointer contents all differ. It checks `ptrRegAddr` before the clock edge and the decoded target after it, so a mix-up between the bank path and the pointer path shows in one of the two. A second instance built without the high RAM half receives the same indirect accesses, so the invalid path is judged against the same stimulus.

// File: rtl/idataPkg.sv
package idataPkg;

  localparam int ADDR_W = 8;
  localparam int BANK_W = 2;
  localparam int REG_W  = 3;
  localparam int BYTE_BITS = 8;
  localparam int IDX_W  = $clog2(BYTE_BITS);

  typedef enum logic [1:0] {
    KIND_DIRECT   = 2'd0,
    KIND_INDIRECT = 2'd1,
    KIND_REG      = 2'd2,
    KIND_BIT      = 2'd3
  } accKind_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_LOWER = 2'd1,
    TGT_UPPER = 2'd2,
    TGT_SFR   = 2'd3
  } tgt_e;

  typedef struct packed {
    logic load;
    logic useDirect;
    logic useIndirect;
    logic useReg;
    logic useBit;
  } strobe_t;

endpackage

// File: rtl/idataCtrl.sv
module idataCtrl
  import idataPkg::*;
(
  input  logic       accValid,
  input  logic [1:0] accKind,
  output strobe_t    stb
);

  accKind_e kind;

  always_comb begin
    kind            = accKind_e'(accKind);
    stb             = '0;
    stb.load        = accValid;
    stb.useDirect   = accValid && (kind == KIND_DIRECT);
    stb.useIndirect = accValid && (kind == KIND_INDIRECT);
    stb.useReg      = accValid && (kind == KIND_REG);
    stb.useBit      = accValid && (kind == KIND_BIT);
  end

endmodule

// File: rtl/idataPath.sv
module idataPath
  import idataPkg::*;
#(
  parameter int          HAS_UPPER   = 1,
  parameter logic [7:0]  BITAREA_BASE = 8'h20
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             stb,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [ADDR_W-1:0]   ptrData,
  input  logic [BANK_W-1:0]   bankSel,
  input  logic                isWrite,
  output logic [ADDR_W-1:0]   ptrRegAddr,
  output logic                outValid,
  output tgt_e                tgtSel,
  output logic [ADDR_W-1:0]   byteAddr,
  output logic [IDX_W-1:0]    bitIdx,
  output logic                invalid,
  output logic                wrEn
);

  localparam int MSB       = ADDR_W - 1;
  localparam int BANKREG_W = BANK_W + REG_W;

  tgt_e upperTgt;
  logic upperInv;

  generate
    if (HAS_UPPER != 0) begin : gUpper
      assign upperTgt = TGT_UPPER;
      assign upperInv = 1'b0;
    end else begin : gNoUpper
      assign upperTgt = TGT_NONE;
      assign upperInv = 1'b1;
    end
  endgenerate

  tgt_e              nTgt;
  logic [ADDR_W-1:0] nByte;
  logic [IDX_W-1:0]  nIdx;
  logic              nInv;

  assign ptrRegAddr = ADDR_W'({bankSel, {(REG_W-1){1'b0}}, addrIn[0]});

  always_comb begin
    nTgt  = TGT_NONE;
    nByte = '0;
    nIdx  = '0;
    nInv  = 1'b0;
    if (stb.useDirect) begin
      nByte = addrIn;
      nTgt  = addrIn[MSB] ? TGT_SFR : TGT_LOWER;
    end
    if (stb.useIndirect) begin
      if (!ptrData[MSB]) begin
        nByte = ptrData;
        nTgt  = TGT_LOWER;
      end else begin
        nByte = upperInv ? '0 : ptrData;
        nTgt  = upperTgt;
        nInv  = upperInv;
      end
    end
    if (stb.useReg) begin
      nByte = ADDR_W'({bankSel, addrIn[REG_W-1:0]});
      nTgt  = TGT_LOWER;
    end
    if (stb.useBit) begin
      nIdx = addrIn[IDX_W-1:0];
      if (!addrIn[MSB]) begin
        nByte = BITAREA_BASE + ADDR_W'(addrIn[MSB-1:IDX_W]);
        nTgt  = TGT_LOWER;
      end else begin
        nByte = {addrIn[MSB:IDX_W], {IDX_W{1'b0}}};
        nTgt  = TGT_SFR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      tgtSel   <= TGT_NONE;
      byteAddr <= '0;
      bitIdx   <= '0;
      invalid  <= 1'b0;
      wrEn     <= 1'b0;
    end else begin
      outValid <= stb.load;
      tgtSel   <= nTgt;
      byteAddr <= nByte;
      bitIdx   <= nIdx;
      invalid  <= nInv;
      wrEn     <= stb.load && isWrite && !nInv;
    end
  end

  logic unusedBits;
  assign unusedBits = ^{BANKREG_W};

endmodule

// File: rtl/idataDecoder.sv
module idataDecoder
  import idataPkg::*;
#(
  parameter int HAS_UPPER = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       accValid,
  input  logic [1:0] accKind,
  input  logic [7:0] addrIn,
  input  logic [7:0] ptrData,
  input  logic [1:0] bankSel,
  input  logic       isWrite,
  output logic [7:0] ptrRegAddr,
  output logic       outValid,
  output logic [1:0] tgtSel,
  output logic [7:0] byteAddr,
  output logic [2:0] bitIdx,
  output logic       invalid,
  output logic       wrEn
);

  strobe_t stb;
  tgt_e    tgtInt;

  idataCtrl u_ctrl (
    .accValid (accValid),
    .accKind  (accKind),
    .stb      (stb)
  );

  idataPath #(.HAS_UPPER(HAS_UPPER)) u_path (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .addrIn     (addrIn),
    .ptrData    (ptrData),
    .bankSel    (bankSel),
    .isWrite    (isWrite),
    .ptrRegAddr (ptrRegAddr),
    .outValid   (outValid),
    .tgtSel     (tgtInt),
    .byteAddr   (byteAddr),
    .bitIdx     (bitIdx),
    .invalid    (invalid),
    .wrEn       (wrEn)
  );

  assign tgtSel = tgtInt;

endmodule

// File: rtl/idataDecoderChk.sv
module idataDecoderChk #(
  parameter int HAS_UPPER = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       accValid,
  input logic [1:0] accKind,
  input logic [7:0] addrIn,
  input logic [7:0] ptrData,
  input logic       outValid,
  input logic [1:0] tgtSel,
  input logic [7:0] byteAddr,
  input logic [2:0] bitIdx,
  input logic       invalid,
  input logic       wrEn
);

  logic pastOk;
  always_ff @(posedge clk) begin
    if (rst) pastOk <= 1'b0;
    else     pastOk <= 1'b1;
  end

  assert_direct_sfr_R3: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(accValid) && $past(accKind) == 2'd0 && $past(addrIn[7]))
      |-> (tgtSel == 2'd3 && byteAddr == $past(addrIn)));

  generate
    if (HAS_UPPER != 0) begin : gChkUpper
      assert_indirect_upper_R4: assert property (@(posedge clk) disable iff (rst)
        (pastOk && $past(accValid) && $past(accKind) == 2'd1 && $past(ptrData[7]))
          |-> (tgtSel == 2'd2 && byteAddr == $past(ptrData) && !invalid));
    end else begin : gChkNoUpper
      assert_absent_upper_R10: assert property (@(posedge clk) disable iff (rst)
        (pastOk && $past(accValid) && $past(accKind) == 2'd1 && $past(ptrData[7]))
          |-> (tgtSel == 2'd0 && invalid && !wrEn));
    end
  endgenerate

  assert_reg_bank_R5: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(accValid) && $past(accKind) == 2'd2)
      |-> (tgtSel == 2'd1 && byteAddr[7:5] == 3'd0 && byteAddr[2:0] == $past(addrIn[2:0])));

  assert_bit_sfr_R8: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(accValid) && $past(accKind) == 2'd3 && $past(addrIn[7]))
      |-> (tgtSel == 2'd3 && byteAddr[2:0] == 3'd0 && bitIdx == $past(addrIn[2:0])));

  assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (pastOk && !$past(accValid)) |-> (!outValid && tgtSel == 2'd0));

  assert_write_gate_R11: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (outValid && !invalid));

endmodule

bind idataDecoder idataDecoderChk #(.HAS_UPPER(HAS_UPPER)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .accValid (accValid),
  .accKind  (accKind),
  .addrIn   (addrIn),
  .ptrData  (ptrData),
  .outValid (outValid),
  .tgtSel   (tgtSel),
  .byteAddr (byteAddr),
  .bitIdx   (bitIdx),
  .invalid  (invalid),
  .wrEn     (wrEn)
);

// File: tb/test_idataDecoder.sv
module test_idataDecoder;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  // {kind[34:33], addr[32:25], ptr[24:17], bank[16:15], wr[14],
  //  expTgt[13:12], expByte[11:4], expIdx[3:1], expWr[0]}
  localparam logic [34:0] VEC [NVEC] = '{
    {2'd0, 8'h45, 8'h00, 2'd0, 1'b0, 2'd1, 8'h45, 3'd0, 1'b0}, // R2 R9 direct low
    {2'd0, 8'h7F, 8'h00, 2'd1, 1'b0, 2'd1, 8'h7F, 3'd0, 1'b0}, // R2 edge
    {2'd0, 8'h80, 8'h00, 2'd0, 1'b1, 2'd3, 8'h80, 3'd0, 1'b1}, // R3 R11
    {2'd0, 8'hF0, 8'h00, 2'd2, 1'b0, 2'd3, 8'hF0, 3'd0, 1'b0}, // R3
    {2'd1, 8'h00, 8'h30, 2'd1, 1'b0, 2'd1, 8'h30, 3'd0, 1'b0}, // R2 indirect low
    {2'd1, 8'h01, 8'h80, 2'd2, 1'b1, 2'd2, 8'h80, 3'd0, 1'b1}, // R4 R11
    {2'd1, 8'h01, 8'hFF, 2'd3, 1'b0, 2'd2, 8'hFF, 3'd0, 1'b0}, // R4
    {2'd2, 8'h05, 8'hAA, 2'd0, 1'b0, 2'd1, 8'h05, 3'd0, 1'b0}, // R5
    {2'd2, 8'h07, 8'h00, 2'd3, 1'b1, 2'd1, 8'h1F, 3'd0, 1'b1}, // R5
    {2'd2, 8'h00, 8'h00, 2'd2, 1'b0, 2'd1, 8'h10, 3'd0, 1'b0}, // R5
    {2'd3, 8'h00, 8'h00, 2'd0, 1'b0, 2'd1, 8'h20, 3'd0, 1'b0}, // R7
    {2'd3, 8'h7F, 8'h00, 2'd1, 1'b0, 2'd1, 8'h2F, 3'd7, 1'b0}, // R7
    {2'd3, 8'h3A, 8'h00, 2'd0, 1'b1, 2'd1, 8'h27, 3'd2, 1'b1}, // R7
    {2'd3, 8'h80, 8'h00, 2'd0, 1'b0, 2'd3, 8'h80, 3'd0, 1'b0}, // R8
    {2'd3, 8'hD5, 8'h00, 2'd2, 1'b0, 2'd3, 8'hD0, 3'd5, 1'b0}, // R8
    {2'd3, 8'hE7, 8'h00, 2'd0, 1'b0, 2'd3, 8'hE0, 3'd7, 1'b0}  // R8
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       accValid = 1'b0;
  logic [1:0] accKind = '0;
  logic [7:0] addrIn = '0;
  logic [7:0] ptrData = '0;
  logic [1:0] bankSel = '0;
  logic       isWrite = 1'b0;

  logic [7:0] ptrRegAddr, byteAddr, ptrRegAddrN, byteAddrN;
  logic       outValid, invalid, wrEn, outValidN, invalidN, wrEnN;
  logic [1:0] tgtSel, tgtSelN;
  logic [2:0] bitIdx, bitIdxN;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idataDecoder #(.HAS_UPPER(1)) i_idataDecoder (
    .clk(clk), .rst(rst), .accValid(accValid), .accKind(accKind), .addrIn(addrIn),
    .ptrData(ptrData), .bankSel(bankSel), .isWrite(isWrite), .ptrRegAddr(ptrRegAddr),
    .outValid(outValid), .tgtSel(tgtSel), .byteAddr(byteAddr), .bitIdx(bitIdx),
    .invalid(invalid), .wrEn(wrEn)
  );

  idataDecoder #(.HAS_UPPER(0)) i_idataDecoder_noUpper (
    .clk(clk), .rst(rst), .accValid(accValid), .accKind(accKind), .addrIn(addrIn),
    .ptrData(ptrData), .bankSel(bankSel), .isWrite(isWrite), .ptrRegAddr(ptrRegAddrN),
    .outValid(outValidN), .tgtSel(tgtSelN), .byteAddr(byteAddrN), .bitIdx(bitIdxN),
    .invalid(invalidN), .wrEn(wrEnN)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] k, input logic [7:0] a,
                       input logic [7:0] p, input logic [1:0] b, input logic w);
    accValid = v; accKind = k; addrIn = a; ptrData = p; bankSel = b; isWrite = w;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", "outValid", outValid, 0);
    check("R1", "tgtSel",   tgtSel,   0);
    check("R1", "byteAddr", byteAddr, 0);
    check("R1", "wrEn",     wrEn,     0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "outValid after reset", outValid, 0);
    check("R1", "invalid after reset",  invalid,  0);

    for (int i = 0; i < NVEC; i++) begin
      drive(1'b1, VEC[i][34:33], VEC[i][32:25], VEC[i][24:17], VEC[i][16:15], VEC[i][14]);
      #1;
      // R6: pointer register location resolved in the same cycle
      check("R6", "ptrRegAddr", ptrRegAddr,
            int'(VEC[i][16:15]) * 8 + int'(VEC[i][25]));
      @(negedge clk);
      check("R12", "outValid", outValid, 1);
      check("R2-R5/R7/R8 tgtSel",   "tgtSel",   tgtSel,   int'(VEC[i][13:12]));
      check("R2-R5/R7/R8 byteAddr", "byteAddr", byteAddr, int'(VEC[i][11:4]));
      check("R7 R8 R9", "bitIdx", bitIdx, int'(VEC[i][3:1]));
      check("R11", "wrEn",    wrEn,    int'(VEC[i][0]));
      check("R11", "invalid", invalid, 0);
    end

    // R12: idle cycle
    drive(1'b0, 2'd0, 8'h90, 8'h00, 2'd0, 1'b1);
    @(negedge clk);
    check("R12", "outValid idle", outValid, 0);
    check("R12", "tgtSel idle",   tgtSel,   0);
    check("R12", "wrEn idle",     wrEn,     0);

    // R10: absent high half, pointer write above 7FH is dropped
    drive(1'b1, 2'd1, 8'h01, 8'h90, 2'd1, 1'b1);
    #1;
    check("R6", "ptrRegAddr bank1 R1", ptrRegAddrN, 8'h09);
    @(negedge clk);
    check("R10", "tgtSel",  tgtSelN,  0);
    check("R10", "invalid", invalidN, 1);
    check("R10", "wrEn",    wrEnN,    0);
    check("R4",  "tgtSel with high half", tgtSel, 2);
    check("R11", "wrEn with high half",   wrEn,   1);

    // R10: pointer below 80H unaffected
    drive(1'b1, 2'd1, 8'h00, 8'h10, 2'd3, 1'b1);
    @(negedge clk);
    check("R10", "low pointer tgtSel",   tgtSelN,   1);
    check("R10", "low pointer byteAddr", byteAddrN, 8'h10);
    check("R10", "low pointer invalid",  invalidN,  0);
    check("R10", "low pointer wrEn",     wrEnN,     1);

    // R3 on the instance without high half: direct SFR still works
    drive(1'b1, 2'd0, 8'h90, 8'h00, 2'd0, 1'b0);
    @(negedge clk);
    check("R3", "direct SFR no-high tgtSel", tgtSelN,  3);
    check("R3", "direct SFR no-high inv",    invalidN, 0);

    // R1: reset in mid-stream clears results
    drive(1'b1, 2'd3, 8'hD5, 8'h00, 2'd0, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "tgtSel reset mid", tgtSel, 0);
    check("R1", "bitIdx reset mid", bitIdx, 0);
    rst = 1'b0;
    drive(1'b0, 2'd0, 8'h00, 8'h00, 2'd0, 1'b0);
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule